// File: doc/BRIEF.md
# Dual-Overflow Watchdog Timer

A watchdog peripheral with a plain valid/write register port clocked by a peripheral clock and a timeout counter clocked by a separate oscillator clock. Software programs a 12-bit period, turns the timer on, and must refresh it at regular intervals. A missed refresh is tolerated once: the first expired period only raises an interrupt, and the reset output fires only when a second period expires in a row with no refresh in between.

Every register write that changes counter behaviour is carried into the oscillator domain through toggle synchronisers. The period value is sampled once, when the enable first reaches the oscillator domain, so a running timer can only be retimed by a module reset followed by a fresh enable. A parity-fault injection register gives software a second, immediate route to the reset output.

Top module: `dual_ovf_wdt`

## Requirements
- R1: After rst_ni is released, wdt_rst_no_o is 1, irq_o is 0, and the control (0x00) and period (0x04) registers read 0.
- R2: The period register at offset 0x04 keeps only write data bits [31:20] as the 12-bit period N; bits [19:0] always read 0.
- R3: The first expired period sets irq_o without touching wdt_rst_no_o; a second consecutive expiry with no refresh drives wdt_rst_no_o low, exactly one period after irq_o rose.
- R4: While bit 0 of the control register has never been written 1, the counter does not advance: irq_o and wdt_rst_no_o stay idle.
- R5: Writing 1 to bit 0 at offset 0x0C (refresh) clears the elapsed count and irq_o; refreshing more often than once per period keeps irq_o at 0 and wdt_rst_no_o at 1.
- R6: One period lasts 2^PRESCALE_W × (N+1) oscillator cycles; with the default PRESCALE_W of 20 this is 1024×1024×(N+1).
- R7: Once enabled, writing 0 to the control register has no effect: it still reads 1 and the timer keeps running until rst_ni.
- R8: A reset pulse holds wdt_rst_no_o low for exactly RST_CYCLES (default 16) oscillator cycles; an overflow-driven pulse also clears irq_o and the overflow state.
- R9: Offsets 0x08, 0x0C, 0x14 and any offset outside 0x00–0x14 read 0.
- R10: The period is captured when the enable reaches the oscillator domain; later writes to 0x04 change the readback but not the running period, and a new value applies after rst_ni and a new enable.
- R11: Any write to offset 0x08 clears the elapsed count without clearing irq_o, delaying the next expiry.
- R12: With the parity-control register (0x10, bit 0) at 0, writing 1 to bit 0 at 0x14 drives wdt_rst_no_o low immediately, even with the timer off; with bit 0 of 0x10 at 1 the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p_i | input | 1 | Peripheral (register) clock |
| clk_osc_i | input | 1 | Oscillator (counter) clock |
| rst_ni | input | 1 | Active-low asynchronous module reset, both domains |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | Write strobe, qualified by req_i |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| irq_o | output | 1 | First-overflow interrupt, oscillator domain |
| wdt_rst_no_o | output | 1 | Active-low reset request pulse, oscillator domain |

## Verification
The bench measures the distance from the interrupt edge to the reset edge in oscillator cycles, since a design that reset on the first expiry, or restarted its period at the interrupt, would show a gap of zero or of the wrong length. It rewrites the period while running and expects the old spacing, catching a design that samples the period continuously. It clears the counter between the two expiries to catch a clear that is dropped or that wrongly clears the interrupt, and it tries to switch the timer off and to inject a parity fault with the gate closed, both of which must leave the outputs untouched.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFF_CTRL   = 'h00;
  localparam int unsigned OFF_PERIOD = 'h04;
  localparam int unsigned OFF_CLR    = 'h08;
  localparam int unsigned OFF_KICK   = 'h0C;
  localparam int unsigned OFF_PECTL  = 'h10;
  localparam int unsigned OFF_PEFRC  = 'h14;

  // event indices carried across the clock boundary
  localparam int unsigned EV_CLR   = 0;
  localparam int unsigned EV_KICK  = 1;
  localparam int unsigned EV_FORCE = 2;
  localparam int unsigned NUM_EV   = 3;
endpackage

// File: rtl/wdt_pulse_sync.sv
module wdt_pulse_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 3
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pulse_i,
  output logic [W-1:0] pulse_o
);
  for (genvar g = 0; g < W; g++) begin : g_ch
    logic              tgl_q;
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge src_clk_i or negedge rst_ni) begin
      if (!rst_ni)         tgl_q <= 1'b0;
      else if (pulse_i[g]) tgl_q <= ~tgl_q;
    end

    always_ff @(posedge dst_clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], tgl_q};
    end

    assign pulse_o[g] = sh_q[STAGES-1] ^ sh_q[STAGES-2];
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned PERIOD_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                en_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic [NUM_EV-1:0]   ev_o
);
  localparam int unsigned PLSB = DATA_W - PERIOD_W;

  logic                en_q, pe_ctl_q;
  logic [PERIOD_W-1:0] period_q;
  logic [NUM_EV-1:0]   ev_q;
  logic                wr;
  logic                unused_wdata;

  assign wr           = req_i & we_i;
  assign unused_wdata = ^wdata_i[PLSB-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      pe_ctl_q <= 1'b0;
      period_q <= '0;
      ev_q     <= '0;
    end else begin
      ev_q <= '0;
      if (wr) begin
        case (addr_i)
          ADDR_W'(OFF_CTRL):   if (wdata_i[0]) en_q <= 1'b1;  // sticky
          ADDR_W'(OFF_PERIOD): period_q <= wdata_i[DATA_W-1:PLSB];
          ADDR_W'(OFF_CLR):    ev_q[EV_CLR] <= 1'b1;
          ADDR_W'(OFF_KICK):   ev_q[EV_KICK] <= wdata_i[0];
          ADDR_W'(OFF_PECTL):  pe_ctl_q <= wdata_i[0];
          ADDR_W'(OFF_PEFRC):  ev_q[EV_FORCE] <= wdata_i[0] & ~pe_ctl_q;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_CTRL):   rdata_o[0] = en_q;
      ADDR_W'(OFF_PERIOD): rdata_o[DATA_W-1:PLSB] = period_q;
      ADDR_W'(OFF_PECTL):  rdata_o[0] = pe_ctl_q;
      default: ;
    endcase
  end

  assign en_o     = en_q;
  assign period_o = period_q;
  assign ev_o     = ev_q;
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned PERIOD_W   = 12,
  parameter int unsigned PRESCALE_W = 20,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                clr_i,
  input  logic                kick_i,
  input  logic                force_i,
  output logic                irq_o,
  output logic                wdt_rst_no
);
  localparam int unsigned RCW = $clog2(RST_CYCLES + 1);

  logic                  run_q, seen_q, irq_q;
  logic [PERIOD_W-1:0]   period_q, unit_q;
  logic [PRESCALE_W-1:0] pre_q;
  logic [RCW-1:0]        rcnt_q;
  logic                  tick, ovf, bite;

  assign tick = &pre_q;
  assign ovf  = run_q & tick & (unit_q == period_q) & ~kick_i & ~clr_i;
  assign bite = ovf & seen_q;

  // period is sampled once, on the first cycle the enable is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      period_q <= '0;
    end else if (en_i && !run_q) begin
      run_q    <= 1'b1;
      period_q <= period_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (clr_i || kick_i) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (run_q) begin
      pre_q <= pre_q + 1'b1;
      if (tick) unit_q <= (unit_q == period_q) ? '0 : unit_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (kick_i || bite) begin
      seen_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (ovf) begin
      seen_q <= 1'b1;
      irq_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rcnt_q <= '0;
    else if (bite || force_i)   rcnt_q <= RCW'(RST_CYCLES);
    else if (rcnt_q != '0)      rcnt_q <= rcnt_q - 1'b1;
  end

  assign irq_o      = irq_q;
  assign wdt_rst_no = (rcnt_q == '0);
endmodule

// File: rtl/dual_ovf_wdt.sv
module dual_ovf_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned PERIOD_W    = 12,
  parameter int unsigned PRESCALE_W  = 20,
  parameter int unsigned RST_CYCLES  = 16,
  parameter int unsigned SYNC_STAGES = 3
) (
  input  logic              clk_p_i,
  input  logic              clk_osc_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wdt_rst_no_o
);
  logic                en_p;
  logic [PERIOD_W-1:0] period_p;
  logic [NUM_EV-1:0]   ev_p, ev_s;
  logic [1:0]          en_sync_q;
  logic                en_s, kick_s, force_s;

  wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)) u_regs (
    .clk_i(clk_p_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .en_o(en_p), .period_o(period_p), .ev_o(ev_p)
  );

  wdt_pulse_sync #(.W(NUM_EV), .STAGES(SYNC_STAGES)) u_evsync (
    .src_clk_i(clk_p_i), .dst_clk_i(clk_osc_i), .rst_ni(rst_ni),
    .pulse_i(ev_p), .pulse_o(ev_s)
  );

  always_ff @(posedge clk_osc_i or negedge rst_ni) begin
    if (!rst_ni) en_sync_q <= '0;
    else         en_sync_q <= {en_sync_q[0], en_p};
  end

  assign en_s    = en_sync_q[1];
  assign kick_s  = ev_s[EV_KICK];
  assign force_s = ev_s[EV_FORCE];

  // period_p is static by the time en_s rises (written before enable)
  wdt_core #(.PERIOD_W(PERIOD_W), .PRESCALE_W(PRESCALE_W), .RST_CYCLES(RST_CYCLES)) u_core (
    .clk_i(clk_osc_i), .rst_ni(rst_ni), .en_i(en_s), .period_i(period_p),
    .clr_i(ev_s[EV_CLR]), .kick_i(kick_s), .force_i(force_s),
    .irq_o(irq_o), .wdt_rst_no(wdt_rst_no_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic kick_i,
  input logic force_i,
  input logic irq_i,
  input logic rst_no_i
);
  p_rst_after_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no_i) |-> ($past(irq_i) || $past(force_i)));

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_i);

  p_kick_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !irq_i);

  p_en_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> en_i);

  p_pulse_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no_i) |=> !rst_no_i);
endmodule

bind dual_ovf_wdt wdt_checker u_chk (
  .clk_i(clk_osc_i), .rst_ni(rst_ni), .en_i(en_s), .kick_i(kick_s),
  .force_i(force_s), .irq_i(irq_o), .rst_no_i(wdt_rst_no_o)
);

// File: tb/dual_ovf_wdt_tb.sv
module dual_ovf_wdt_tb;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 32;

  logic clk = 1'b0, osc = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic irq, wrst_n;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz
  always #15 osc = ~osc;

  dual_ovf_wdt #(.PRESCALE_W(3)) u_dut (
    .clk_p_i(clk), .clk_osc_i(osc), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wdt_rst_no_o(wrst_n)
  );

  task automatic chk(input bit ok, input string req_s, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_s, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [DW-1:0] per(input int n);
    return {n[11:0], 20'h0};
  endfunction

  // osc cycles from irq rise to reset fall; also irq level when reset seen
  task automatic gap(output int c, output logic irq_at);
    int w = 0;
    c = 0;
    while (!irq && w < 600) begin @(negedge osc); w++; end
    while (wrst_n && c < 600) begin @(negedge osc); c++; end
    irq_at = irq;
  endtask

  task automatic pulse_width(output int c);
    c = 0;
    while (!wrst_n && c < 100) begin c++; @(negedge osc); end
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] d;
    do_reset();
    chk(wrst_n === 1'b1, "R1 rst idle", wrst_n, 1);
    chk(irq === 1'b0, "R1 irq idle", irq, 0);
    rd(5'h00, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(5'h04, d); chk(d == 0, "R1 period", d, 0);
  endtask

  task automatic t_regmap();
    logic [DW-1:0] d;
    do_reset();
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, d); chk(d == 32'hFFF0_0000, "R2 period mask", d, 32'hFFF0_0000);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d); chk(d == 0, "R9 clr reads 0", d, 0);
    rd(5'h0C, d); chk(d == 0, "R9 kick reads 0", d, 0);
    rd(5'h14, d); chk(d == 0, "R9 force reads 0", d, 0);
    rd(5'h18, d); chk(d == 0, "R9 unmapped", d, 0);
  endtask

  task automatic t_disabled();
    bit bad = 1'b0;
    do_reset();
    wr(5'h04, per(0));
    repeat (300) begin @(negedge osc); if (irq || !wrst_n) bad = 1'b1; end
    chk(!bad, "R4 idle while disabled", bad, 0);
  endtask

  task automatic t_two_ovf();
    int c = 0, gp, pw;
    logic ia;
    do_reset();
    wr(5'h04, per(1));
    wr(5'h00, 32'h1);
    while (!irq && c < 200) begin @(negedge osc); c++; end
    chk(c >= 16 && c <= 26, "R6 first expiry latency", c, 16);
    chk(wrst_n === 1'b1, "R3 no reset on first expiry", wrst_n, 1);
    gap(gp, ia);
    chk(gp == 16, "R3 R6 irq to reset gap", gp, 16);
    chk(ia === 1'b0, "R8 irq cleared by bite", ia, 0);
    pulse_width(pw);
    chk(pw == 16, "R8 pulse width", pw, 16);
  endtask

  task automatic t_refresh();
    bit bad = 1'b0;
    int w = 0;
    do_reset();
    wr(5'h04, per(1));
    wr(5'h00, 32'h1);
    while (!irq && w < 200) begin @(negedge osc); w++; end
    wr(5'h0C, 32'h1);
    repeat (10) @(negedge osc);
    chk(irq === 1'b0, "R5 kick clears irq", irq, 0);
    for (int i = 0; i < 40; i++) begin
      wr(5'h0C, 32'h1);
      repeat (6) begin @(negedge osc); if (irq || !wrst_n) bad = 1'b1; end
    end
    chk(!bad, "R5 steady kicks keep quiet", bad, 0);
  endtask

  task automatic t_sticky();
    logic [DW-1:0] d;
    int w = 0;
    do_reset();
    wr(5'h04, per(1));
    wr(5'h00, 32'h1);
    wr(5'h00, 32'h0);
    rd(5'h00, d); chk(d == 1, "R7 enable sticky", d, 1);
    while (!irq && w < 200) begin @(negedge osc); w++; end
    chk(irq === 1'b1, "R7 still running", irq, 1);
  endtask

  task automatic t_period_locked();
    logic [DW-1:0] d;
    int gp;
    logic ia;
    do_reset();
    wr(5'h04, per(1));
    wr(5'h00, 32'h1);
    repeat (8) @(negedge osc);
    wr(5'h04, per(3));
    rd(5'h04, d); chk(d == per(3), "R10 readback updates", d, per(3));
    gap(gp, ia);
    chk(gp == 16, "R10 running period unchanged", gp, 16);
    do_reset();
    wr(5'h04, per(3));
    wr(5'h00, 32'h1);
    gap(gp, ia);
    chk(gp == 32, "R10 R6 new period after reset", gp, 32);
  endtask

  task automatic t_counter_clear();
    int w = 0, c = 8;
    do_reset();
    wr(5'h04, per(1));
    wr(5'h00, 32'h1);
    while (!irq && w < 200) begin @(negedge osc); w++; end
    repeat (8) @(negedge osc);
    wr(5'h08, 32'h0);
    chk(irq === 1'b1, "R11 clear keeps irq", irq, 1);
    while (wrst_n && c < 300) begin @(negedge osc); c++; end
    chk(c > 20, "R11 clear delays expiry", c, 30);
  endtask

  task automatic t_force();
    int c = 0, pw;
    bit bad = 1'b0;
    do_reset();
    wr(5'h14, 32'h1);
    while (wrst_n && c < 40) begin @(negedge osc); c++; end
    chk(c <= 12, "R12 forced reset latency", c, 6);
    pulse_width(pw);
    chk(pw == 16, "R12 R8 forced pulse width", pw, 16);
    do_reset();
    wr(5'h10, 32'h1);
    wr(5'h14, 32'h1);
    repeat (40) begin @(negedge osc); if (!wrst_n) bad = 1'b1; end
    chk(!bad, "R12 gated force ignored", bad, 0);
  endtask

  initial begin
    t_reset_state();
    t_regmap();
    t_disabled();
    t_two_ovf();
    t_refresh();
    t_sticky();
    t_period_locked();
    t_counter_clear();
    t_force();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule